// File: doc/BRIEF.md
# Counter/Timer with Selectable Clock

This block is a 16-bit down-counter that works either as an event counter or as a free-running square-wave timer. One 3-bit select code chooses the mode and the clock source together. The sources are an external pin, two transmitter 1x clocks and the system clock, and the pin and system-clock sources each have a divide-by-16 variant. Every source is brought into the system clock domain as a one-cycle enable, and the count moves only on cycles where that enable is high.

In counter mode a start command loads the preload value and starts counting. The ready flag rises at terminal count, the count then wraps and keeps going, and a stop command halts the count and clears the flag. In timer mode the count reloads from the preload value each time it reaches zero and the square-wave output flips on every reload. The ready flag marks each full cycle of the wave. In this mode a stop command only clears the flag and the timer keeps running.

Top module: `ctmr_top`

## Requirements
- R1: After synchronous reset, `ready_o` and `sq_o` are 0, the counter is idle and the count is 0.
- R2: `mode_sel_i[2]` = 0 (codes 0 to 3) selects counter mode and `mode_sel_i[2]` = 1 (codes 4 to 7) selects timer mode. In counter mode nothing counts until a start command is given. In timer mode counting runs with no start command.
- R3: The source is chosen by code: 0 and 4 use the external pin, 1 and 5 use the external pin divided by 16, 2 uses the channel A transmit clock, 3 uses the channel B transmit clock, 6 uses the system clock (a tick on every cycle) and 7 uses the system clock divided by 16. Sources that are not selected have no effect.
- R4: A divided source gives one tick on every 16th tick of its base source. Every base tick of the selected source advances a 4-bit prescaler. A start command clears the prescaler, so the first divided tick comes on the 16th base tick after the start.
- R5: In counter mode, `start_i` loads `preload_i`. Each tick then lowers the count by one, and the count wraps from 0 to 0xFFFF and keeps counting. `ready_o` rises on the tick that takes the count from 1 to 0.
- R6: In counter mode, `stop_i` halts counting and clears `ready_o`. The count stays where it is until the next `start_i`.
- R7: In timer mode, a tick at count 0 reloads `preload_i` and inverts `sq_o`. Every other tick lowers the count by one. `ready_o` rises when `sq_o` goes from 1 to 0, which is once per square-wave period. A start command reloads `preload_i` and leaves `sq_o` unchanged.
- R8: In timer mode, `stop_i` clears `ready_o` and the count and `sq_o` carry on as if no stop had been given.
- R9: The pin and transmit-clock inputs pass through a two-stage synchronizer. A rising edge makes one tick: the edge is sampled at clock edge k, the tick is seen at clock edge k+2 and the state changes after edge k+2. The pin is accepted whatever its I/O configuration.
- R10: When `stop_i` is asserted in the same cycle in which `ready_o` would set, `ready_o` stays 0. When `start_i` and `stop_i` are asserted together in counter mode, the preload is loaded and the counter is left halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. It is also the crystal source. |
| rst | input | 1 | Synchronous reset, active high |
| ext_clk_i | input | 1 | External pin clock, asynchronous |
| txa_clk_i | input | 1 | Channel A transmitter 1x clock, asynchronous |
| txb_clk_i | input | 1 | Channel B transmitter 1x clock, asynchronous |
| preload_i | input | 16 | Preload value for the count |
| start_i | input | 1 | Start command. Loads the preload and clears the prescaler. |
| stop_i | input | 1 | Stop command. Clears ready and halts counter mode. |
| mode_sel_i | input | 3 | Select code for mode and clock source |
| sq_o | output | 1 | Square-wave output of timer mode |
| ready_o | output | 1 | Ready status flag |

## Verification
The hardest situation to reach is the counter wrap. With a preload of 0, the flag may rise only after the count has gone through 0xFFFF and all the way down again, which takes 65536 ticks. The bench toggles the channel A clock on every cycle, so a tick arrives every second cycle. It then checks that the flag is still low just before the 65536th tick and high just after it. To cover prescaler phase and synchronizer latency, the pin and transmit clocks run all the time at different periods, so every select code meets edges that are unrelated to the start command.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    localparam int CTR_W_DEF   = 16;
    localparam int PRESC_W_DEF = 4;
    localparam int SEL_W       = 3;

    typedef enum logic [1:0] {
        SRC_PIN = 2'd0,
        SRC_TXA = 2'd1,
        SRC_TXB = 2'd2,
        SRC_SYS = 2'd3
    } src_e;

    typedef struct packed {
        logic timer;
        logic div16;
        src_e src;
    } sel_t;

    function automatic sel_t decode_sel(input logic [SEL_W-1:0] code);
        sel_t s;
        s.timer = code[2];
        s.div16 = (code == 3'b001) || (code == 3'b101) || (code == 3'b111);
        case (code)
            3'b010:         s.src = SRC_TXA;
            3'b011:         s.src = SRC_TXB;
            3'b110, 3'b111: s.src = SRC_SYS;
            default:        s.src = SRC_PIN;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ctmr_edge.sv
module ctmr_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

    // R9: a rising edge yields a single-cycle tick
    a_r9_single_tick: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ctmr_presc.sv
module ctmr_presc #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic tick_i,
    output logic pulse_o
);
    logic [W-1:0] cnt_q;

    assign pulse_o = tick_i & (cnt_q == '1);

    always_ff @(posedge clk) begin
        if (rst || clr_i) cnt_q <= '0;
        else if (tick_i)  cnt_q <= cnt_q + 1'b1;
    end

    // R4: after a divided tick the prescaler starts a new group
    a_r4_presc_wrap: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> (cnt_q == '0));
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core #(
    parameter int CTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             timer_i,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [CTR_W-1:0] preload_i,
    output logic             sq_o,
    output logic             ready_o
);
    localparam logic [CTR_W-1:0] ONE = CTR_W'(1);

    logic [CTR_W-1:0] cnt_q;
    logic             run_q;
    logic             sq_q;
    logic             rdy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
            sq_q  <= 1'b0;
            rdy_q <= 1'b0;
        end else begin
            if (start_i) begin
                cnt_q <= preload_i;
                if (!timer_i) run_q <= 1'b1;
            end else if (tick_i) begin
                if (timer_i) begin
                    if (cnt_q == '0) begin
                        cnt_q <= preload_i;
                        sq_q  <= ~sq_q;
                        if (sq_q) rdy_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end else if (run_q) begin
                    cnt_q <= cnt_q - ONE;
                    if (cnt_q == ONE) rdy_q <= 1'b1;
                end
            end
            if (stop_i) begin
                rdy_q <= 1'b0;
                if (!timer_i) run_q <= 1'b0;
            end
        end
    end

    assign sq_o    = sq_q;
    assign ready_o = rdy_q;

    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!rdy_q && !sq_q));

    // R6: a halted counter holds its count
    a_r6_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (!timer_i && !run_q && !start_i) |=> (cnt_q == $past(cnt_q)));

    // R10: stop always leaves ready low
    a_r10_stop_wins: assert property (@(posedge clk) disable iff (rst)
        stop_i |=> !rdy_q);

    // R8: timer keeps counting down regardless of stop
    a_r8_timer_runs: assert property (@(posedge clk) disable iff (rst)
        (timer_i && tick_i && !start_i && (cnt_q != '0))
        |=> (cnt_q == $past(cnt_q) - ONE));

    // R7: reload at zero flips the square wave
    a_r7_toggle: assert property (@(posedge clk) disable iff (rst)
        (timer_i && tick_i && !start_i && (cnt_q == '0)) |=> (sq_q != $past(sq_q)));
endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter int CTR_W       = CTR_W_DEF,
    parameter int PRESC_W     = PRESC_W_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_clk_i,
    input  logic             txa_clk_i,
    input  logic             txb_clk_i,
    input  logic [CTR_W-1:0] preload_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [SEL_W-1:0] mode_sel_i,
    output logic             sq_o,
    output logic             ready_o
);
    localparam int NSRC = 3;

    logic [NSRC-1:0] pins;
    logic [NSRC-1:0] rises;
    sel_t            sel;
    logic            base_tick;
    logic            div_tick;
    logic            tick;

    assign pins = {txb_clk_i, txa_clk_i, ext_clk_i};

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_sync
            ctmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk     (clk),
                .rst     (rst),
                .async_i (pins[i]),
                .rise_o  (rises[i])
            );
        end
    endgenerate

    assign sel = decode_sel(mode_sel_i);

    always_comb begin
        case (sel.src)
            SRC_PIN: base_tick = rises[0];
            SRC_TXA: base_tick = rises[1];
            SRC_TXB: base_tick = rises[2];
            default: base_tick = 1'b1;
        endcase
    end

    ctmr_presc #(.W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (start_i),
        .tick_i  (base_tick),
        .pulse_o (div_tick)
    );

    assign tick = sel.div16 ? div_tick : base_tick;

    ctmr_core #(.CTR_W(CTR_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .timer_i   (sel.timer),
        .tick_i    (tick),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .preload_i (preload_i),
        .sq_o      (sq_o),
        .ready_o   (ready_o)
    );
endmodule

// File: tb/ctmr_top_tb_top.sv
`timescale 1ns/1ps
module ctmr_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk_i = 1'b0;
    logic        txa_clk_i = 1'b0;
    logic        txb_clk_i = 1'b0;
    logic [15:0] preload_i = 16'd0;
    logic        start_i = 1'b0;
    logic        stop_i = 1'b0;
    logic [2:0]  mode_sel_i = 3'd0;
    logic        sq_o;
    logic        ready_o;

    int    checks = 0;
    int    failures = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ctmr_top dut_i (
        .clk(clk), .rst(rst), .ext_clk_i(ext_clk_i), .txa_clk_i(txa_clk_i),
        .txb_clk_i(txb_clk_i), .preload_i(preload_i), .start_i(start_i),
        .stop_i(stop_i), .mode_sel_i(mode_sel_i), .sq_o(sq_o), .ready_o(ready_o)
    );

    // free-running source clocks with unrelated periods
    int ec = 0;
    int bc = 0;
    always @(negedge clk) begin
        if (!rst) begin
            txa_clk_i <= ~txa_clk_i;
            ec = ec + 1;
            if (ec == 3) begin ec = 0; ext_clk_i <= ~ext_clk_i; end
            bc = bc + 1;
            if (bc == 5) begin bc = 0; txb_clk_i <= ~txb_clk_i; end
        end
    end

    // behavioural reference model
    int m_cnt, m_pre;
    bit m_run, m_sq, m_rdy;
    bit hist[3][3]; // per source: samples from three, two and one edges ago
    always @(posedge clk) begin
        bit rise[3];
        bit pins[3];
        bit base, tick, tmr, dv;
        int src;
        pins[0] = ext_clk_i; pins[1] = txa_clk_i; pins[2] = txb_clk_i;
        if (rst) begin
            m_cnt = 0; m_pre = 0; m_run = 0; m_sq = 0; m_rdy = 0;
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++) hist[i][j] = 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                rise[i] = hist[i][1] && !hist[i][0];
                hist[i][0] = hist[i][1];
                hist[i][1] = hist[i][2];
                hist[i][2] = pins[i];
            end
            tmr = mode_sel_i[2];
            dv  = (mode_sel_i == 3'd1) || (mode_sel_i == 3'd5) || (mode_sel_i == 3'd7);
            case (mode_sel_i)
                3'd2: src = 1;
                3'd3: src = 2;
                3'd6, 3'd7: src = 3;
                default: src = 0;
            endcase
            base = (src == 3) ? 1'b1 : rise[src];
            tick = dv ? (base && m_pre == 15) : base;
            if (start_i) m_pre = 0;
            else if (base) m_pre = (m_pre + 1) % 16;
            if (start_i) begin
                m_cnt = preload_i;
                if (!tmr) m_run = 1;
            end else if (tick) begin
                if (tmr) begin
                    if (m_cnt == 0) begin
                        m_cnt = preload_i;
                        if (m_sq) m_rdy = 1;
                        m_sq = !m_sq;
                    end else m_cnt = m_cnt - 1;
                end else if (m_run) begin
                    if (m_cnt == 1) m_rdy = 1;
                    m_cnt = (m_cnt == 0) ? 65535 : m_cnt - 1;
                end
            end
            if (stop_i) begin
                m_rdy = 0;
                if (!tmr) m_run = 0;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            checks++;
            if (sq_o !== m_sq || ready_o !== m_rdy) begin
                failures++;
                $display("FAIL %s model: sq=%b ready=%b expected sq=%b ready=%b at cycle %0d",
                         cur_req, sq_o, ready_o, m_sq, m_rdy, cycles);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input logic [2:0] code, input logic [15:0] pre);
        @(negedge clk);
        mode_sel_i = code; preload_i = pre; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 195000 && !done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int toggles;
        logic prev;
        wait_cyc(4);
        chk("R1", ready_o, 1'b0, "ready after reset");
        chk("R1", sq_o, 1'b0, "sq after reset");
        @(negedge clk) rst = 1'b0;
        wait_cyc(2);
        chk("R1", ready_o, 1'b0, "ready after release");

        // R2: counter mode idles without a start
        cur_req = "R2"; mode_sel_i = 3'd2;
        wait_cyc(40);
        chk("R2", ready_o, 1'b0, "counter idle before start");

        // R5: terminal count on channel A clock
        cur_req = "R5";
        do_start(3'd2, 16'd5);
        wait_cyc(30);
        chk("R5", ready_o, 1'b1, "ready after terminal count");

        // R6: stop clears and halts
        cur_req = "R6";
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        chk("R6", ready_o, 1'b0, "ready cleared by stop");
        do_start(3'd2, 16'd6);
        wait_cyc(4);
        do_stop();
        wait_cyc(40);
        chk("R6", ready_o, 1'b0, "halted counter never reaches terminal");

        // R3 / R9: other counter sources
        cur_req = "R3";
        do_start(3'd3, 16'd3);
        wait_cyc(60);
        chk("R3", ready_o, 1'b1, "channel B source reaches terminal");
        do_stop();
        cur_req = "R9";
        do_start(3'd0, 16'd3);
        wait_cyc(40);
        chk("R9", ready_o, 1'b1, "pin source reaches terminal");
        do_stop();

        // R4: pin divided by 16 in counter mode
        cur_req = "R4";
        do_start(3'd1, 16'd2);
        wait_cyc(150);
        chk("R4", ready_o, 1'b0, "divided pin not yet at terminal");
        wait_cyc(120);
        chk("R4", ready_o, 1'b1, "divided pin reaches terminal");
        do_stop();

        // R7: timer on system clock
        cur_req = "R7";
        do_start(3'd6, 16'd3);
        wait_cyc(20);
        prev = sq_o; toggles = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (sq_o !== prev) toggles++;
            prev = sq_o;
        end
        checks++;
        if (toggles != 20) begin
            failures++;
            $display("FAIL R7 toggle count: actual=%0d expected=20", toggles);
        end
        chk("R7", ready_o, 1'b1, "ready set by full period");

        // R8: stop in timer mode does not halt
        cur_req = "R8";
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        chk("R8", ready_o, 1'b0, "timer stop clears ready");
        prev = sq_o; toggles = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sq_o !== prev) toggles++;
            prev = sq_o;
        end
        checks++;
        if (toggles != 10) begin
            failures++;
            $display("FAIL R8 toggles after stop: actual=%0d expected=10", toggles);
        end

        // R10: stop held across ready setting points
        cur_req = "R10";
        @(negedge clk) stop_i = 1'b1;
        wait_cyc(50);
        chk("R10", ready_o, 1'b0, "stop held keeps ready low");
        stop_i = 1'b0;
        @(negedge clk) begin start_i = 1'b1; stop_i = 1'b1; mode_sel_i = 3'd2; preload_i = 16'd2; end
        @(negedge clk) begin start_i = 1'b0; stop_i = 1'b0; end
        wait_cyc(30);
        chk("R10", ready_o, 1'b0, "start with stop leaves counter halted");

        // R4 / R2: timer divided sources, timer with no start
        cur_req = "R4";
        do_start(3'd7, 16'd1);
        wait_cyc(200);
        cur_req = "R2";
        mode_sel_i = 3'd4; preload_i = 16'd2;
        wait_cyc(120);
        cur_req = "R4";
        do_start(3'd5, 16'd0);
        wait_cyc(400);
        do_stop();

        // R5: wrap from 0 to 0xFFFF, 65536 ticks to terminal
        cur_req = "R5";
        do_start(3'd2, 16'd0);
        wait_cyc(130000);
        chk("R5", ready_o, 1'b0, "no terminal before wrap completes");
        wait_cyc(1500);
        chk("R5", ready_o, 1'b1, "terminal after wrap");

        finish_run();
    end
endmodule